// File: doc/BRIEF.md
# Instruction Fetch Queue with Dual In-Order Dispatch

This block is a six-entry in-order instruction buffer that sits between an instruction cache and the execution pipelines. Each cycle the fetcher can write up to four instructions into it. The block tells the fetcher how many instructions to request. That request is based on how many slots were empty at the end of the previous cycle, so the request output comes straight from a register and has no path back from the current cycle's dispatch decision.

The two oldest entries are offered to the dispatch logic. It grants each of them separately. An entry is dispatched only if it is a normal instruction, and the second entry can leave only when the first one also leaves in that cycle. Every entry is visible to a branch scanner, which can pull out branch-class entries (branches, interrupt returns, system calls, instruction synchronisation) from any position. Whatever remains is compacted toward slot 0 in the same cycle, in program order, and new instructions are appended behind it. A flush empties the queue after a mispredicted branch.

Top module: `fetch_iq`

## Requirements
- R1: After reset the queue is empty: `count` is 0, every `slotValid` bit is 0, and `fetchReq` is 4.
- R2: `fetchReq` equals the number of empty slots at the end of the previous cycle, capped at 4.
- R3: Valid fill lanes are appended behind the surviving entries in lane order (lane 0 first). Lanes whose valid bit is 0 are skipped. Valid lanes that do not fit in the room left after this cycle's removals are dropped.
- R4: A normal entry leaves only from slot 0 or slot 1, when its grant bit is set. Slot 1 leaves only if slot 0 leaves in the same cycle. `dispTaken[k]` is 1 exactly for the slots that leave this way.
- R5: An entry whose class bit is 1 (branch-class) is never dispatched by `dispGrant`. Its `dispTaken` bit stays 0 and the entry stays in the queue.
- R6: An entry with class bit 1 in any valid slot j is removed when `branchTake[j]` is 1, and `branchTaken[j]` reports this. `branchTake` has no effect on normal entries or on empty slots.
- R7: After removals, the surviving entries move toward slot 0 in the same cycle and keep their relative order. The valid slots always form a contiguous run starting at slot 0.
- R8: A flush empties the queue at the next edge. It overrides fills, grants and branch takes in that cycle: `dispTaken` and `branchTaken` read 0, and `fetchReq` becomes 4 on the following cycle.
- R9: The queue never holds more than 6 entries, and `count` always equals the number of valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every entry; overrides all other inputs this cycle |
| fillValid | input | 4 | Per-lane valid bits of incoming instructions |
| fillIsBranch | input | 4 | Per-lane class bit, 1 = branch-class |
| fillInsn | input | 4*INSN_W | Incoming instruction words, lane k at bits [k*INSN_W +: INSN_W] |
| fetchReq | output | 3 | Number of instructions the fetcher should supply this cycle |
| dispGrant | input | 2 | Dispatch grants for slot 0 (bit 0) and slot 1 (bit 1) |
| dispTaken | output | 2 | Slots actually dispatched this cycle |
| branchTake | input | 6 | Branch scanner removal request per slot |
| branchTaken | output | 6 | Slots actually removed by the branch scanner this cycle |
| slotValid | output | 6 | Valid bit per slot |
| slotIsBranch | output | 6 | Class bit per slot |
| slotInsn | output | 6*INSN_W | Instruction word per slot, slot j at bits [j*INSN_W +: INSN_W] |
| count | output | 3 | Number of valid entries |

## Verification
The bench aims at the following failure modes:
- A grant on slot 1 while slot 0 is blocked by a branch-class entry. A design that lets slot 1 go would dispatch out of order.
- Branch removal from the middle of a full queue at the same time as a bottom dispatch. Faulty compaction would reorder or duplicate the survivors.
- The fetcher supplying all four lanes while the queue is nearly full. A queue without a room check would overwrite entries or report a count above six.
- A flush arriving together with fills and grants. If the flush did not win, instructions from the wrong path would survive it, and `fetchReq` would not snap back to four afterwards.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
  localparam int unsigned IQ_DEPTH = 6;
  localparam int unsigned IQ_FILL  = 4;
  localparam int unsigned IQ_DISP  = 2;
  localparam int unsigned CNT_W    = $clog2(IQ_DEPTH + 1);
  localparam int unsigned REQ_W    = $clog2(IQ_FILL + 1);

  typedef struct packed {
    logic                clearAll;
    logic [IQ_DEPTH-1:0] keep;
    logic [IQ_FILL-1:0]  accept;
  } iqStrobe_t;
endpackage

// File: rtl/fiq_data.sv
module fiq_data
  import fiq_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  iqStrobe_t                    strobe,
  input  logic [IQ_FILL*INSN_W-1:0]    fillInsn,
  input  logic [IQ_FILL-1:0]           fillIsBranch,
  output logic [IQ_DEPTH-1:0]          slotValid,
  output logic [IQ_DEPTH-1:0]          slotIsBranch,
  output logic [IQ_DEPTH*INSN_W-1:0]   slotInsn
);
  logic [INSN_W-1:0]   entInsn [IQ_DEPTH];
  logic [IQ_DEPTH-1:0] entValid, entBr;
  logic [INSN_W-1:0]   nxtInsn [IQ_DEPTH];
  logic [IQ_DEPTH-1:0] nxtValid, nxtBr;

  // Prefix placement: surviving entries first, then accepted lanes.
  always_comb begin
    int pos;
    pos = 0;
    nxtValid = '0;
    nxtBr    = '0;
    for (int i = 0; i < IQ_DEPTH; i++) nxtInsn[i] = '0;
    for (int j = 0; j < IQ_DEPTH; j++) begin
      if (strobe.keep[j] && pos < IQ_DEPTH) begin
        nxtInsn[pos]  = entInsn[j];
        nxtBr[pos]    = entBr[j];
        nxtValid[pos] = 1'b1;
        pos++;
      end
    end
    for (int l = 0; l < IQ_FILL; l++) begin
      if (strobe.accept[l] && pos < IQ_DEPTH) begin
        nxtInsn[pos]  = fillInsn[l*INSN_W +: INSN_W];
        nxtBr[pos]    = fillIsBranch[l];
        nxtValid[pos] = 1'b1;
        pos++;
      end
    end
    if (strobe.clearAll) nxtValid = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) entValid <= '0;
    else       entValid <= nxtValid;
  end

  always_ff @(posedge clk) begin
    entBr <= nxtBr;
    for (int i = 0; i < IQ_DEPTH; i++) entInsn[i] <= nxtInsn[i];
  end

  generate
    for (genvar g = 0; g < IQ_DEPTH; g++) begin : gOut
      assign slotInsn[g*INSN_W +: INSN_W] = entInsn[g];
    end
  endgenerate
  assign slotValid    = entValid;
  assign slotIsBranch = entBr;

  logic [IQ_DEPTH:0] validPlusOne;
  assign validPlusOne = {1'b0, entValid} + (IQ_DEPTH+1)'(1);

  // R7: valid slots stay packed from slot 0 upward
  a_r7_packed: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(validPlusOne));
  // R8: a flush strobe leaves no valid slot at the next edge
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (entValid == '0));
endmodule

// File: rtl/fiq_ctrl.sv
module fiq_ctrl
  import fiq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  logic [IQ_FILL-1:0]  fillValid,
  input  logic [IQ_DISP-1:0]  dispGrant,
  input  logic [IQ_DEPTH-1:0] branchTake,
  input  logic [IQ_DEPTH-1:0] slotValid,
  input  logic [IQ_DEPTH-1:0] slotIsBranch,
  output iqStrobe_t           strobe,
  output logic [IQ_DISP-1:0]  dispTaken,
  output logic [IQ_DEPTH-1:0] branchTaken,
  output logic [REQ_W-1:0]    fetchReq,
  output logic [CNT_W-1:0]    count
);
  logic [IQ_DEPTH-1:0] removeMask, keepMask;
  logic [IQ_FILL-1:0]  acceptMask;
  logic [CNT_W-1:0]    keptCnt, room, nextCount;

  always_comb begin
    for (int k = 0; k < IQ_DISP; k++) begin
      dispTaken[k] = !flush && slotValid[k] && !slotIsBranch[k] && dispGrant[k];
      if (k > 0) dispTaken[k] = dispTaken[k] && dispTaken[k-1];
    end
    branchTaken = flush ? '0 : (slotValid & slotIsBranch & branchTake);
    removeMask  = branchTaken;
    removeMask[IQ_DISP-1:0] = removeMask[IQ_DISP-1:0] | dispTaken;
    keepMask    = flush ? '0 : (slotValid & ~removeMask);
  end

  always_comb begin
    int taken;
    taken      = 0;
    keptCnt    = CNT_W'($countones(keepMask));
    room       = CNT_W'(IQ_DEPTH) - keptCnt;
    acceptMask = '0;
    for (int l = 0; l < IQ_FILL; l++) begin
      if (!flush && fillValid[l] && taken < int'(room)) begin
        acceptMask[l] = 1'b1;
        taken++;
      end
    end
    nextCount = keptCnt + CNT_W'(taken);
  end

  assign strobe.clearAll = flush;
  assign strobe.keep     = keepMask;
  assign strobe.accept   = acceptMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      fetchReq <= REQ_W'(IQ_FILL);
    end else begin
      count <= nextCount;
      if ((IQ_DEPTH - nextCount) > IQ_FILL) fetchReq <= REQ_W'(IQ_FILL);
      else fetchReq <= REQ_W'(IQ_DEPTH - nextCount);
    end
  end

  // R9: occupancy bound and agreement with the datapath
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (count <= IQ_DEPTH) && (count == CNT_W'($countones(slotValid))));
  // R2: request never exceeds the fill width, full width when empty
  a_r2_req_cap: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq <= IQ_FILL) && ((count == 0) -> (fetchReq == IQ_FILL)));
  // R4: slot 1 only leaves together with slot 0
  a_r4_in_order: assert property (@(posedge clk) disable iff (!rstN)
    dispTaken[1] |-> dispTaken[0]);
  // R5: a branch-class entry at the bottom is never dispatched
  a_r5_no_branch_disp: assert property (@(posedge clk) disable iff (!rstN)
    dispTaken[0] |-> !slotIsBranch[0]);
  // R6: the branch scanner removes only branch-class entries
  a_r6_branch_only: assert property (@(posedge clk) disable iff (!rstN)
    (branchTaken & ~slotIsBranch) == '0);
  // R8: flush empties and restores the full request
  a_r8_flush_reset: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == 0) && (fetchReq == IQ_FILL));
endmodule

// File: rtl/fetch_iq.sv
module fetch_iq
  import fiq_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic [IQ_FILL-1:0]         fillValid,
  input  logic [IQ_FILL-1:0]         fillIsBranch,
  input  logic [IQ_FILL*INSN_W-1:0]  fillInsn,
  output logic [REQ_W-1:0]           fetchReq,
  input  logic [IQ_DISP-1:0]         dispGrant,
  output logic [IQ_DISP-1:0]         dispTaken,
  input  logic [IQ_DEPTH-1:0]        branchTake,
  output logic [IQ_DEPTH-1:0]        branchTaken,
  output logic [IQ_DEPTH-1:0]        slotValid,
  output logic [IQ_DEPTH-1:0]        slotIsBranch,
  output logic [IQ_DEPTH*INSN_W-1:0] slotInsn,
  output logic [CNT_W-1:0]           count
);
  iqStrobe_t strobe;

  fiq_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .flush        (flush),
    .fillValid    (fillValid),
    .dispGrant    (dispGrant),
    .branchTake   (branchTake),
    .slotValid    (slotValid),
    .slotIsBranch (slotIsBranch),
    .strobe       (strobe),
    .dispTaken    (dispTaken),
    .branchTaken  (branchTaken),
    .fetchReq     (fetchReq),
    .count        (count)
  );

  fiq_data #(.INSN_W(INSN_W)) i_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fillInsn     (fillInsn),
    .fillIsBranch (fillIsBranch),
    .slotValid    (slotValid),
    .slotIsBranch (slotIsBranch),
    .slotInsn     (slotInsn)
  );
endmodule

// File: tb/test_fetch_iq.sv
module test_fetch_iq;
  localparam int PERIOD = 10;
  localparam int W = 32;
  localparam int D = 6;
  localparam int F = 4;

  logic clk = 1'b0;
  logic rstN, flush;
  logic [F-1:0] fillValid, fillIsBranch;
  logic [F*W-1:0] fillInsn;
  logic [2:0] fetchReq, count;
  logic [1:0] dispGrant, dispTaken;
  logic [D-1:0] branchTake, branchTaken, slotValid, slotIsBranch;
  logic [D*W-1:0] slotInsn;

  always #(PERIOD/2) clk = ~clk;

  fetch_iq #(.INSN_W(W)) i_fetch_iq (
    .clk(clk), .rstN(rstN), .flush(flush), .fillValid(fillValid),
    .fillIsBranch(fillIsBranch), .fillInsn(fillInsn), .fetchReq(fetchReq),
    .dispGrant(dispGrant), .dispTaken(dispTaken), .branchTake(branchTake),
    .branchTaken(branchTaken), .slotValid(slotValid), .slotIsBranch(slotIsBranch),
    .slotInsn(slotInsn), .count(count)
  );

  int checks = 0;
  int errors = 0;
  logic [W:0] mq[$];
  int mReq = F;
  int seq = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int phase);
    flush = 1'b0;
    for (int l = 0; l < F; l++) begin
      fillValid[l]          = (phase == 0) ? 1'b1 : ($urandom_range(3) != 0);
      fillIsBranch[l]       = (phase == 2) ? ($urandom_range(1) == 0) : ($urandom_range(3) == 0);
      fillInsn[l*W +: W]    = W'(seq);
      seq++;
    end
    dispGrant  = (phase == 0) ? 2'b00 : 2'($urandom_range(3));
    branchTake = (phase == 0) ? '0 : D'($urandom_range(63));
    if (phase == 3) flush = ($urandom_range(7) == 0);
    else if (phase == 1) flush = ($urandom_range(63) == 0);
  endtask

  task automatic step(input int phase);
    logic [1:0] eDisp;
    logic [D-1:0] eBr;
    logic [W:0] nq[$];
    int n;
    @(negedge clk);
    drive(phase);
    #1;
    n = mq.size();
    eDisp[0] = !flush && n > 0 && !mq[0][W] && dispGrant[0];
    eDisp[1] = !flush && n > 1 && !mq[1][W] && dispGrant[1] && eDisp[0];
    for (int j = 0; j < D; j++) eBr[j] = !flush && j < n && mq[j][W] && branchTake[j];
    chk(dispTaken == eDisp, "R4/R5", "dispTaken", dispTaken, eDisp);
    chk(branchTaken == eBr, "R6", "branchTaken", branchTaken, eBr);
    nq = {};
    if (!flush) begin
      for (int j = 0; j < n; j++)
        if (!(eBr[j] || (j < 2 && eDisp[j]))) nq.push_back(mq[j]);
      for (int l = 0; l < F; l++)
        if (fillValid[l] && nq.size() < D) nq.push_back({fillIsBranch[l], fillInsn[l*W +: W]});
    end
    mq = nq;
    mReq = (D - mq.size() > F) ? F : D - mq.size();
    @(posedge clk);
    #1;
    chk(count == 3'(mq.size()), flush ? "R8" : "R9", "count", count, mq.size());
    chk(fetchReq == 3'(mReq), "R2", "fetchReq", fetchReq, mReq);
    for (int j = 0; j < D; j++) begin
      chk(slotValid[j] == (j < mq.size()), "R7", "slotValid", slotValid, j);
      if (j < mq.size()) begin
        chk(slotInsn[j*W +: W] == mq[j][W-1:0], "R3", "slotInsn", slotInsn[j*W +: W], mq[j][W-1:0]);
        chk(slotIsBranch[j] == mq[j][W], "R3", "slotIsBranch", slotIsBranch[j], mq[j][W]);
      end
    end
  endtask

  initial begin
    rstN = 1'b0; flush = 1'b0; fillValid = '0; fillIsBranch = '0;
    fillInsn = '0; dispGrant = '0; branchTake = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(count == 0, "R1", "count", count, 0);
    chk(slotValid == '0, "R1", "slotValid", slotValid, 0);
    chk(fetchReq == 3'(F), "R1", "fetchReq", fetchReq, F);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) step(0);
    for (int i = 0; i < 800; i++) step(1);
    for (int i = 0; i < 3; i++) step(0);
    for (int i = 0; i < 800; i++) step(2);
    for (int i = 0; i < 800; i++) step(3);
    for (int i = 0; i < 400; i++) step(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule